// File: doc/BRIEF.md
# Masked XOR Scan-Out Compactor

This block merges many internal scan-chain outputs into a smaller set of scan-out channels. The chains are split into equal groups, one group per channel. On every shift cycle each channel emits the XOR of the chains in its group that are enabled by a per-chain mask. Setting all mask bits gives full compaction. Leaving exactly one bit set in a group turns that channel into a direct view of a single chain, so a failing chain can be isolated cell by cell during diagnosis.

The mask is a shift register loaded one bit per cycle while shifting is off. It is frozen while shifting is on, so it cannot change during an unload. Each channel bit is registered and appears one clock after the chain bits that produced it.

The number of chains per channel is a parameter and must be one of 2, 4, 8, 16, 32 or 64. Any other value stops elaboration.

Top module: `mxc_compactor`

## Requirements
- R1: While `rst` is high, and at the first sample after it, every channel output is 0 and every mask bit is 1.
- R2: Chain c belongs to channel c / CHAINS_PER_CH. When `shift_en` is 1 in a cycle, each channel output in the next cycle equals the XOR of that cycle's chain bits in its group whose mask bit is 1. Mask bit c gates chain c.
- R3: With every mask bit of a group at 1, the channel output is the XOR of all chains in that group.
- R4: With exactly one mask bit of a group at 1, the channel output reproduces that chain's bit stream, delayed by one cycle.
- R5: With every mask bit of a group at 0, the channel output is 0 during shifting, whatever the chains carry.
- R6: In a cycle with `shift_en` = 0 and `mask_ld_en` = 1, `mask_ld_bit` enters mask bit NUM_CHAINS-1 and every other bit moves down one place. After NUM_CHAINS such cycles, the first bit loaded sits in mask bit 0.
- R7: While `shift_en` is 1, `mask_ld_en` has no effect, and the mask keeps its value through the unload.
- R8: In the cycle after one with `shift_en` = 0, every channel output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Unload in progress; chains are sampled and compacted |
| chain_in | input | NUM_CHANNELS*CHAINS_PER_CH | Serial outputs of the internal chains, bit c = chain c |
| mask_ld_en | input | 1 | Shift one bit into the mask (only when `shift_en` is 0) |
| mask_ld_bit | input | 1 | Serial mask data |
| chan_out | output | NUM_CHANNELS | Registered compacted scan-out bits |

## Verification
Two functions can fall in the same cycle: a mask load request and an active unload. The bench raises `mask_ld_en` with toggling data in the middle of compacted and single-chain unloads. The behavioural model keeps the old mask in those cycles, and the outputs are compared on every clock, so any stray mask update shows up as a wrong channel bit. Shift-enable falling in the same cycle as the first load bit is also exercised. The check there is that the load takes effect and the outputs clear one cycle later.

// File: rtl/mxc_pkg.sv
package mxc_pkg;
  // Supported compaction ratios: powers of two from 2 to 64.
  function automatic bit ratio_supported(input int ratio);
    return (ratio == 2) || (ratio == 4) || (ratio == 8) ||
           (ratio == 16) || (ratio == 32) || (ratio == 64);
  endfunction
endpackage

// File: rtl/mxc_mask_reg.sv
module mxc_mask_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             load_en,
  input  logic             load_bit,
  output logic [WIDTH-1:0] mask_q
);
  // New bits enter at the top and walk toward bit 0.
  // Loading is blocked while an unload is in progress.
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '1;
    else if (load_en && !shift_en)
      mask_q <= {load_bit, mask_q[WIDTH-1:1]};
  end
endmodule

// File: rtl/mxc_xor_lane.sv
module mxc_xor_lane #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] chains,
  input  logic [WIDTH-1:0] mask,
  output logic             out_q
);
  localparam int LEVELS = $clog2(WIDTH);

  // Balanced XOR tree, with the gated chain bits at the leaves (level 0).
  logic [WIDTH-1:0] tree [LEVELS+1];

  assign tree[0] = chains & mask;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int NODES = WIDTH >> (lv + 1);
    for (genvar n = 0; n < NODES; n++) begin : g_node
      assign tree[lv+1][n] = tree[lv][2*n] ^ tree[lv][2*n+1];
    end
    if (NODES < WIDTH) begin : g_pad
      assign tree[lv+1][WIDTH-1:NODES] = '0;
    end
  end

  // Registered output: tree result while shifting, 0 otherwise.
  always_ff @(posedge clk) begin
    if (rst)
      out_q <= 1'b0;
    else
      out_q <= shift_en & tree[LEVELS][0];
  end
endmodule

// File: rtl/mxc_compactor.sv
module mxc_compactor #(
  parameter int NUM_CHANNELS  = 2,
  parameter int CHAINS_PER_CH = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                shift_en,
  input  logic [NUM_CHANNELS*CHAINS_PER_CH-1:0] chain_in,
  input  logic                                mask_ld_en,
  input  logic                                mask_ld_bit,
  output logic [NUM_CHANNELS-1:0]             chan_out
);
  localparam int NUM_CHAINS = NUM_CHANNELS * CHAINS_PER_CH;

  if (!mxc_pkg::ratio_supported(CHAINS_PER_CH)) begin : g_bad_ratio
    $error("mxc_compactor: unsupported chains-per-channel ratio");
  end

  logic [NUM_CHAINS-1:0] mask_q;

  mxc_mask_reg #(.WIDTH(NUM_CHAINS)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .load_en  (mask_ld_en),
    .load_bit (mask_ld_bit),
    .mask_q   (mask_q)
  );

  // One lane per channel; chain c feeds lane c / CHAINS_PER_CH.
  for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : g_lane
    mxc_xor_lane #(.WIDTH(CHAINS_PER_CH)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .chains   (chain_in[ch*CHAINS_PER_CH +: CHAINS_PER_CH]),
      .mask     (mask_q[ch*CHAINS_PER_CH +: CHAINS_PER_CH]),
      .out_q    (chan_out[ch])
    );
  end
endmodule

// File: rtl/mxc_compactor_chk.sv
module mxc_compactor_chk #(
  parameter int NUM_CHANNELS  = 2,
  parameter int CHAINS_PER_CH = 4
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  shift_en,
  input logic [NUM_CHANNELS*CHAINS_PER_CH-1:0] chain_in,
  input logic                                  mask_ld_en,
  input logic                                  mask_ld_bit,
  input logic [NUM_CHANNELS*CHAINS_PER_CH-1:0] mask_q,
  input logic [NUM_CHANNELS-1:0]               chan_out
);
  localparam int N = NUM_CHANNELS * CHAINS_PER_CH;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> (chan_out == '0)); // R8

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> $stable(mask_q)); // R7

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && mask_ld_en) |=> (mask_q[N-1] == $past(mask_ld_bit))); // R6

  for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : g_ch
    AST_SINGLE_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (shift_en && $countones(mask_q[ch*CHAINS_PER_CH +: CHAINS_PER_CH]) == 1)
      |=> (chan_out[ch] == $past(|(chain_in[ch*CHAINS_PER_CH +: CHAINS_PER_CH]
                                   & mask_q[ch*CHAINS_PER_CH +: CHAINS_PER_CH])))); // R4

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
      (shift_en && mask_q[ch*CHAINS_PER_CH +: CHAINS_PER_CH] == '0)
      |=> !chan_out[ch]); // R5
  end
endmodule

bind mxc_compactor mxc_compactor_chk #(
  .NUM_CHANNELS  (NUM_CHANNELS),
  .CHAINS_PER_CH (CHAINS_PER_CH)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .shift_en    (shift_en),
  .chain_in    (chain_in),
  .mask_ld_en  (mask_ld_en),
  .mask_ld_bit (mask_ld_bit),
  .mask_q      (mask_q),
  .chan_out    (chan_out)
);

// File: tb/mxc_compactor_tb.sv
module mxc_compactor_tb;
  localparam int NCH = 2;
  localparam int CPC = 4;
  localparam int N   = NCH * CPC;

  logic           clk = 1'b0;
  logic           rst;
  logic           shift_en;
  logic [N-1:0]   chain_in;
  logic           mask_ld_en;
  logic           mask_ld_bit;
  logic [NCH-1:0] chan_out;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_mask;   // behavioural copy of the mask
  logic [N-1:0] last_chains;

  always #10 clk = ~clk;  // 50 MHz

  mxc_compactor #(.NUM_CHANNELS(NCH), .CHAINS_PER_CH(CPC)) u_dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .chain_in(chain_in),
    .mask_ld_en(mask_ld_en), .mask_ld_bit(mask_ld_bit), .chan_out(chan_out)
  );

  task automatic check(input logic [NCH-1:0] act, input logic [NCH-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at a falling edge, update the model, compare at the next falling edge.
  task automatic step(input logic sh, input logic [N-1:0] ch, input logic ld,
                      input logic b, input string tag);
    logic [NCH-1:0] exp;
    shift_en = sh; chain_in = ch; mask_ld_en = ld; mask_ld_bit = b;
    for (int c = 0; c < NCH; c++) begin
      int ones = 0;
      for (int k = 0; k < CPC; k++)
        if (m_mask[c*CPC+k] && ch[c*CPC+k]) ones++;
      exp[c] = sh ? ((ones % 2) == 1) : 1'b0;
    end
    if (ld && !sh) m_mask = {b, m_mask[N-1:1]};
    last_chains = ch;
    @(posedge clk);
    @(negedge clk);
    check(chan_out, exp, tag);
  endtask

  task automatic load_mask(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) step(1'b0, 8'hA5 ^ N'(i), 1'b1, m[i], "R6");
  endtask

  function automatic logic [N-1:0] pat(input int i);
    return N'((i * 37) ^ (i << 3) ^ (i >> 2));
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; shift_en = 1'b0; chain_in = '0; mask_ld_en = 1'b0; mask_ld_bit = 1'b0;
    m_mask = '1;
    repeat (3) @(negedge clk);
    check(chan_out, '0, "R1 reset");
    rst = 1'b0;

    // R1/R3: reset mask is all ones, so full compaction right away.
    for (int i = 0; i < 20; i++) step(1'b1, pat(i), 1'b0, 1'b0, "R3 full compaction");

    // R8: idle with chain activity gives zeros.
    for (int i = 0; i < 5; i++) step(1'b0, pat(i + 50), 1'b0, 1'b0, "R8 idle");

    // R6/R4: select chain 1 on channel 0 and chain 6 on channel 1.
    load_mask(8'b0100_0010);
    for (int i = 0; i < 24; i++) begin
      logic [N-1:0] p;
      p = pat(i + 7);
      step(1'b1, p, 1'b0, 1'b0, "R4 single chain");
      check(chan_out, {p[6], p[1]}, "R4 stream equals chain");
    end

    // R5: channel 1 fully masked, channel 0 open.
    load_mask(8'b0000_1111);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, pat(i + 90) | 8'hF0, 1'b0, 1'b0, "R5 empty mask");
      check({chan_out[1], 1'b0}, 2'b00, "R5 masked channel zero");
    end

    // R2: mixed mask.
    load_mask(8'b1011_0110);
    for (int i = 0; i < 16; i++) step(1'b1, pat(i + 130), 1'b0, 1'b0, "R2 mixed mask");

    // R7: load requests during unload are ignored (collision with shifting).
    for (int i = 0; i < 16; i++) step(1'b1, pat(i + 170), 1'b1, i[0], "R7 load during shift");

    // Shift drops in the same cycle as a load: load takes effect, output clears.
    step(1'b0, pat(3), 1'b1, 1'b1, "R8 shift off with load");
    for (int i = 1; i < N; i++) step(1'b0, pat(i), 1'b1, 1'b0, "R6 load rest");
    // Now mask = 8'b0000_0001: channel 0 sees chain 0 only, channel 1 fully masked.
    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] p;
      p = pat(i + 210);
      step(1'b1, p, 1'b0, 1'b0, "R6 load order");
      check(chan_out, {1'b0, p[0]}, "R6 first loaded bit gates chain 0");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule